// File: doc/BRIEF.md
# Serial Crosspoint Configuration Controller

This block is the digital control plane of a routing matrix with 32 inputs and 16 outputs. A host writes one configuration word into a serial chain: one bit for each rising edge of a shift clock, and only while the active-low select is held low. One six-bit field per output holds an enable flag and a five-bit input index. A trailing bit turns the input clamp on or off. The bit that falls off the far end of the chain appears on a serial output, so several controllers can be cascaded on one data line.

The chain is double buffered. A holding register copies the chain whenever the update line is low and freezes while update is high, so routes change only when the host pulses update. Each output field is decoded into a one-hot row of 32 select lines, gated by that output's enable. The result is a 16 × 32 select matrix, a 16-bit enable vector and a clamp flag. All four serial-side inputs are brought into the system clock through synchroniser stages. A shift clock edge is found by comparing consecutive synchronised samples. Reset clears the chain and the holding register, so every output is disabled.

Top module: `xpt_cfg_ctrl`

## Requirements
- R1: After reset, out_en is all zeros, route_sel is all zeros, clamp_en is 0 and sdo is 0.
- R2: The chain shifts only on a rising edge of sclk while csn is low. Edges while csn is high leave the chain unchanged.
- R3: The first bit shifted in is the enable of output 15. Then come the remaining fields from output 15 down to output 0, each sent most significant bit first, and the clamp bit is last.
- R4: In each six-bit field the top bit is the output enable (1 = enabled) and the lower five bits are the binary input index, most significant bit first.
- R5: Row k of route_sel (bits k*32 to k*32+31) has exactly bit i set when output k is enabled with index i. The row is all zeros when output k is disabled, and out_en[k] follows the enable bit.
- R6: While upd is high, out_en, route_sel and clamp_en hold their values even as new bits are shifted in.
- R7: While upd is low, the holding register is transparent, and the outputs follow the chain contents without a rising edge on upd.
- R8: sdo presents the bit at the far end of the chain. That bit is the earliest-shifted bit still held, so during a new load sdo replays the previous word in its original order.
- R9: Asserting reset disables every output whatever was latched before. Afterwards an update pulse with no new shifting keeps every output disabled.
- R10: clamp_en equals the last bit shifted in, once it has been updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| sclk | input | 1 | Serial shift clock, asynchronous |
| csn | input | 1 | Active-low chain select, asynchronous |
| sdi | input | 1 | Serial data in, asynchronous |
| upd | input | 1 | Update line: low = transparent, high = hold |
| sdo | output | 1 | Far-end chain bit for cascading |
| route_sel | output | 512 | One-hot select rows, 32 bits per output |
| out_en | output | 16 | Per-output enable |
| clamp_en | output | 1 | Input clamp enable |

## Verification
The bench sweeps 32 words, so that every output is routed from every one of the 32 inputs with enables mixed in. A swapped field, a reversed index or a misplaced clamp bit would therefore show up as a wrong row or a stray enable. It shifts a second word with update held high: a design that let the holding register leak would change routes early, and one that tapped the wrong chain end would give a different replay on sdo. Shift clock pulses sent with select high must leave the routes intact, which catches a design that ignores select. A reset followed by a bare update pulse must leave all outputs disabled, which catches a design that clears only the holding register and reloads stale chain data.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;

   // decoder implementation variants
   typedef enum logic {
      DEC_SHIFT   = 1'b0,
      DEC_COMPARE = 1'b1
   } dec_style_e;

   // position of the lowest bit of an output field in the chain;
   // chain bit 0 always holds the clamp flag (last bit shifted in)
   function automatic int field_base(input int out_idx, input int field_w);
      return 1 + out_idx * field_w;
   endfunction

   function automatic int chain_len(input int num_out, input int field_w);
      return num_out * field_w + 1;
   endfunction

endpackage

// File: rtl/xpt_sync.sv
module xpt_sync #(
   parameter int              WIDTH   = 1,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("xpt_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("xpt_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/xpt_shift_chain.sv
module xpt_shift_chain #(
   parameter int CHAIN_W = 97
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               sclk_s,
   input  logic               csn_s,
   input  logic               sdi_s,
   output logic               shift_fire,
   output logic [CHAIN_W-1:0] chain_q,
   output logic               tail_bit
);

   generate
      if (CHAIN_W < 2) begin : g_bad_len
         $error("xpt_shift_chain: CHAIN_W must be at least 2");
      end
   endgenerate

   logic sclk_prev;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) sclk_prev <= 1'b0;
      else     sclk_prev <= sclk_s;
   end

   // rising edge of the synchronised shift clock, gated by select
   assign shift_fire = sclk_s & ~sclk_prev & ~csn_s;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)             chain_q <= '0;
      else if (shift_fire) chain_q <= {chain_q[CHAIN_W-2:0], sdi_s};
   end

   assign tail_bit = chain_q[CHAIN_W-1];

endmodule

// File: rtl/xpt_hold_latch.sv
module xpt_hold_latch #(
   parameter int W = 97
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         hold_s,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   // clocked model of a level latch: follows d while hold is low
   always_ff @(posedge clk or posedge rst) begin
      if (rst)          q <= '0;
      else if (!hold_s) q <= d;
   end

endmodule

// File: rtl/xpt_row_decoder.sv
module xpt_row_decoder
   import xpt_cfg_pkg::*;
#(
   parameter int         NUM_IN    = 32,
   parameter int         SEL_W     = 5,
   parameter dec_style_e DEC_STYLE = DEC_COMPARE
) (
   input  logic              en,
   input  logic [SEL_W-1:0]  sel,
   output logic [NUM_IN-1:0] row
);

   generate
      if (NUM_IN > (1 << SEL_W)) begin : g_bad_sel
         $error("xpt_row_decoder: SEL_W too narrow for NUM_IN");
      end

      if (DEC_STYLE == DEC_SHIFT) begin : g_shift
         assign row = en ? (NUM_IN'(1) << sel) : '0;
      end else begin : g_compare
         always_comb begin
            for (int i = 0; i < NUM_IN; i++)
               row[i] = en && (sel == SEL_W'(i));
         end
      end
   endgenerate

endmodule

// File: rtl/xpt_cfg_ctrl.sv
module xpt_cfg_ctrl
   import xpt_cfg_pkg::*;
#(
   parameter int         NUM_OUT     = 16,
   parameter int         NUM_IN      = 32,
   parameter int         SYNC_STAGES = 2,
   parameter dec_style_e DEC_STYLE   = DEC_COMPARE
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      sclk,
   input  logic                      csn,
   input  logic                      sdi,
   input  logic                      upd,
   output logic                      sdo,
   output logic [NUM_OUT*NUM_IN-1:0] route_sel,
   output logic [NUM_OUT-1:0]        out_en,
   output logic                      clamp_en
);

   localparam int SEL_W   = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
   localparam int FIELD_W = SEL_W + 1;
   localparam int CHAIN_W = chain_len(NUM_OUT, FIELD_W);

   generate
      if (NUM_OUT < 1) begin : g_bad_out
         $error("xpt_cfg_ctrl: NUM_OUT must be at least 1");
      end
      if (NUM_IN < 2) begin : g_bad_in
         $error("xpt_cfg_ctrl: NUM_IN must be at least 2");
      end
   endgenerate

   logic upd_s, csn_s, sclk_s, sdi_s;
   logic shift_fire;
   logic [CHAIN_W-1:0] chain_q;
   logic [CHAIN_W-1:0] latch_q;

   // idle values: update holding, select inactive
   xpt_sync #(
      .WIDTH  (4),
      .STAGES (SYNC_STAGES),
      .RST_VAL(4'b1100)
   ) u_sync (
      .clk(clk),
      .rst(rst),
      .d  ({upd, csn, sclk, sdi}),
      .q  ({upd_s, csn_s, sclk_s, sdi_s})
   );

   xpt_shift_chain #(.CHAIN_W(CHAIN_W)) u_chain (
      .clk       (clk),
      .rst       (rst),
      .sclk_s    (sclk_s),
      .csn_s     (csn_s),
      .sdi_s     (sdi_s),
      .shift_fire(shift_fire),
      .chain_q   (chain_q),
      .tail_bit  (sdo)
   );

   xpt_hold_latch #(.W(CHAIN_W)) u_latch (
      .clk   (clk),
      .rst   (rst),
      .hold_s(upd_s),
      .d     (chain_q),
      .q     (latch_q)
   );

   assign clamp_en = latch_q[0];

   generate
      for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
         localparam int BASE = field_base(k, FIELD_W);
         assign out_en[k] = latch_q[BASE+SEL_W];
         xpt_row_decoder #(
            .NUM_IN   (NUM_IN),
            .SEL_W    (SEL_W),
            .DEC_STYLE(DEC_STYLE)
         ) u_dec (
            .en (latch_q[BASE+SEL_W]),
            .sel(latch_q[BASE +: SEL_W]),
            .row(route_sel[k*NUM_IN +: NUM_IN])
         );
      end
   endgenerate

endmodule

// File: rtl/xpt_cfg_ctrl_chk.sv
module xpt_cfg_ctrl_chk #(
   parameter int NUM_OUT = 16,
   parameter int NUM_IN  = 32,
   parameter int CHAIN_W = 97
) (
   input logic                      clk,
   input logic                      rst,
   input logic                      hold_s,
   input logic                      shift_fire,
   input logic                      sdi_s,
   input logic [CHAIN_W-1:0]        chain_q,
   input logic [NUM_OUT*NUM_IN-1:0] route_sel,
   input logic [NUM_OUT-1:0]        out_en,
   input logic                      clamp_en
);

   // R2: without a qualified shift edge the chain keeps its contents
   assert_chain_idle_R2: assert property (@(posedge clk) disable iff (rst)
      !shift_fire |=> $stable(chain_q));

   // R3: a qualified edge moves the chain one place and takes the new bit at the near end
   assert_shift_order_R3: assert property (@(posedge clk) disable iff (rst)
      shift_fire |=> (chain_q[0] == $past(sdi_s)) &&
                     (chain_q[CHAIN_W-1:1] == $past(chain_q[CHAIN_W-2:0])));

   // R6: update high freezes every decoded output
   assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
      hold_s |=> $stable(out_en) && $stable(route_sel) && $stable(clamp_en));

   generate
      for (genvar k = 0; k < NUM_OUT; k++) begin : g_row
         // R5: at most one input per output
         assert_row_onehot_R5: assert property (@(posedge clk) disable iff (rst)
            $onehot0(route_sel[k*NUM_IN +: NUM_IN]));
         // R5: a row is live exactly when its output is enabled
         assert_row_enable_R5: assert property (@(posedge clk) disable iff (rst)
            out_en[k] == (|route_sel[k*NUM_IN +: NUM_IN]));
      end
   endgenerate

endmodule

bind xpt_cfg_ctrl xpt_cfg_ctrl_chk #(
   .NUM_OUT(NUM_OUT),
   .NUM_IN (NUM_IN),
   .CHAIN_W(CHAIN_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .hold_s    (upd_s),
   .shift_fire(shift_fire),
   .sdi_s     (sdi_s),
   .chain_q   (chain_q),
   .route_sel (route_sel),
   .out_en    (out_en),
   .clamp_en  (clamp_en)
);

// File: tb/xpt_cfg_ctrl_test.sv
`timescale 1ns/1ps
module xpt_cfg_ctrl_test;

   localparam int NO = 16;
   localparam int NI = 32;
   localparam int SW = 5;
   localparam int CL = NO * (SW + 1) + 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sclk = 1'b0;
   logic csn = 1'b1;
   logic sdi = 1'b0;
   logic upd = 1'b1;
   logic sdo;
   logic [NO*NI-1:0] route_sel;
   logic [NO-1:0]    out_en;
   logic             clamp_en;

   always #2.5 clk = ~clk;

   xpt_cfg_ctrl uut (
      .clk(clk), .rst(rst), .sclk(sclk), .csn(csn), .sdi(sdi), .upd(upd),
      .sdo(sdo), .route_sel(route_sel), .out_en(out_en), .clamp_en(clamp_en)
   );

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic          m_en  [NO];
   logic [SW-1:0] m_idx [NO];
   logic          m_clamp;
   logic          stream     [CL];
   logic          old_stream [CL];

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic check1(input string req, input logic [NO*NI-1:0] act,
                         input logic [NO*NI-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // turn the model word into the serial order of R3
   task automatic build_stream();
      int p = 0;
      for (int o = NO - 1; o >= 0; o--) begin
         stream[p] = m_en[o]; p++;
         for (int b = SW - 1; b >= 0; b--) begin
            stream[p] = m_idx[o][b]; p++;
         end
      end
      stream[p] = m_clamp;
   endtask

   task automatic set_word(input int k);
      for (int o = 0; o < NO; o++) begin
         m_idx[o] = SW'((o * 5 + k) % NI);
         m_en[o]  = ((o + k) % 4) != 3;
      end
      m_clamp = k[0];
      build_stream();
   endtask

   task automatic send_bit(input logic b);
      sdi = b; sclk = 1'b0; tick(4);
      sclk = 1'b1; tick(4);
      sclk = 1'b0;
   endtask

   // shift the model word; optionally check the replay on sdo (R8)
   task automatic shift_word(input bit chk_sdo);
      csn = 1'b0;
      for (int j = 0; j < CL; j++) begin
         sdi = stream[j]; tick(2);
         if (chk_sdo)
            check1("R8 sdo replay", {{(NO*NI-1){1'b0}}, sdo},
                   {{(NO*NI-1){1'b0}}, old_stream[j]});
         send_bit(stream[j]);
      end
      tick(2);
      csn = 1'b1;
      tick(2);
   endtask

   task automatic pulse_update();
      upd = 1'b0; tick(4);
      upd = 1'b1; tick(4);
   endtask

   task automatic save_old();
      for (int j = 0; j < CL; j++) old_stream[j] = stream[j];
   endtask

   task automatic check_cfg(input string req);
      logic [NO*NI-1:0] er;
      logic [NO*NI-1:0] ee;
      er = '0; ee = '0;
      for (int o = 0; o < NO; o++) begin
         ee[o] = m_en[o];
         if (m_en[o]) er[o*NI + int'(m_idx[o])] = 1'b1;
      end
      check1({req, " route_sel"}, route_sel, er);
      check1({req, " out_en"}, {{(NO*NI-NO){1'b0}}, out_en}, ee);
      check1({req, " clamp_en R10"}, {{(NO*NI-1){1'b0}}, clamp_en},
             {{(NO*NI-1){1'b0}}, m_clamp});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         report();
      end
   end

   initial begin
      tick(3);
      rst = 1'b0;
      tick(4);

      // R1: reset state
      for (int o = 0; o < NO; o++) begin m_en[o] = 1'b0; m_idx[o] = '0; end
      m_clamp = 1'b0;
      check_cfg("R1 reset");
      check1("R1 sdo", {{(NO*NI-1){1'b0}}, sdo}, '0);

      // R3 R4 R5 R10: every output takes every input index once
      for (int k = 0; k < NI; k++) begin
         set_word(k);
         shift_word(1'b0);
         pulse_update();
         check_cfg("R3 R4 R5 sweep");
      end

      // R2: shift clock edges with select high are ignored
      csn = 1'b1;
      for (int j = 0; j < CL; j++) send_bit(~stream[j]);
      tick(2);
      pulse_update();
      check_cfg("R2 select high");

      // R6 R8: new word shifted with update high
      save_old();
      set_word(7);
      m_en[3] = 1'b1; m_idx[3] = 5'd31; m_en[12] = 1'b0; m_clamp = 1'b1;
      build_stream();
      begin
         logic          s_en  [NO];
         logic [SW-1:0] s_idx [NO];
         logic          s_cl;
         s_en = m_en; s_idx = m_idx; s_cl = m_clamp;
         for (int o = 0; o < NO; o++) begin
            m_en[o] = old_stream[(NO-1-o)*(SW+1)];
            for (int b = 0; b < SW; b++)
               m_idx[o][SW-1-b] = old_stream[(NO-1-o)*(SW+1) + 1 + b];
         end
         m_clamp = old_stream[CL-1];
         shift_word(1'b1);
         check_cfg("R6 hold");
         m_en = s_en; m_idx = s_idx; m_clamp = s_cl;
      end
      pulse_update();
      check_cfg("R6 after update");

      // R7: transparent while update low
      set_word(18);
      upd = 1'b0;
      tick(4);
      shift_word(1'b0);
      tick(4);
      check_cfg("R7 transparent");
      upd = 1'b1;
      tick(4);

      // R9: reset disables everything, stale data does not return
      rst = 1'b1; tick(2);
      rst = 1'b0; tick(4);
      for (int o = 0; o < NO; o++) m_en[o] = 1'b0;
      m_clamp = 1'b0;
      check_cfg("R9 reset");
      pulse_update();
      check_cfg("R9 bare update");
      check1("R9 sdo", {{(NO*NI-1){1'b0}}, sdo}, '0);

      report();
   end

endmodule